// File: doc/BRIEF.md
# Software-Filled Fully Associative Translation Buffer

This block holds a small set of page translations that software loads one at a time. A translation is built in two steps. An address insert claims a slot, writes the virtual page range and the physical page number, and leaves the slot invalid. A following protection insert on the same address writes the access fields and makes the slot valid. Software can also drop a single page or empty the whole buffer. A lookup port compares a virtual address against every slot and returns the physical page and protection fields one cycle later, or reports a miss.

To claim a slot, the address insert walks the buffer one slot per cycle. Any valid slot that already covers the new page is emptied. The highest-indexed empty slot seen during the walk is the one that gets written. When the walk finds no empty slot, a round-robin pointer picks the victim. Commands use a valid/ready handshake. Lookups are accepted on every cycle.

Top module: `swtlb`

## Requirements
- R1: After reset every slot is empty, every lookup misses, `cmd_ready` is 1, `cmd_err` is 0 and the round-robin pointer is 0.
- R2: A lookup request produces `lk_rsp_valid` exactly one cycle later. Slots are compared in ascending index order, and a slot matches when its begin address is less than or equal to the lookup address and the lookup address is less than or equal to its end address. The first match supplies `lk_rsp_ppn` and `lk_rsp_prot`.
- R3: The response reports a miss (`lk_rsp_miss`=1, with ppn and prot both zero) when no slot matches or when the first matching slot is not yet valid. There is only one kind of miss.
- R4: Address insert (`cmd_op`=0) sets begin to the vaddr with its low 12 bits cleared and end to begin+4095. It takes the physical page number from `cmd_data[24:5]`, clears the protection fields and leaves the slot invalid. After the accepting edge `cmd_ready` stays low for NUM_ENT+1 cycles.
- R5: During the address insert walk, each invalid slot and each valid slot covering the vaddr counts as free, and each such valid slot is emptied. The free slot with the highest index receives the new page.
- R6: When the walk finds no free slot, the slot at the round-robin pointer is overwritten. The pointer then advances by one and wraps from NUM_ENT-1 to 0. Purge-all does not move it.
- R7: Protection insert (`cmd_op`=1) writes `cmd_data[29:1]` into the first matching slot and makes it valid. `lk_rsp_prot` bit k equals data bit k+1: access id [17:0], user bit [18], second privilege level [20:19], first privilege level [22:21], rights type [25:23], and three attribute bits B [26], D [27] and T [28].
- R8: A protection insert whose address matches no slot, or whose first matching slot is already valid, changes nothing. It pulses `cmd_err` high for one cycle after the accepting edge. No other command raises `cmd_err`.
- R9: Page purge (`cmd_op`=2) empties the first matching slot only if that slot is valid. An invalid match is left in place. An emptied slot has begin all ones and end zero, so it matches no address.
- R10: Purge-all (`cmd_op`=3) empties every slot in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 2 | 0 address insert, 1 protection insert, 2 page purge, 3 purge all |
| cmd_vaddr | input | 32 | Virtual address of the command |
| cmd_data | input | 32 | Data word: ppn in [24:5] or protection in [29:1] |
| cmd_err | output | 1 | One-cycle pulse for a rejected protection insert |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_rsp_valid | output | 1 | Lookup response present |
| lk_rsp_miss | output | 1 | Lookup missed |
| lk_rsp_ppn | output | 20 | Physical page number on a hit |
| lk_rsp_prot | output | 29 | Protection fields on a hit |

## Verification
The assertions assume `cmd_op`, `cmd_vaddr` and `cmd_data` are sampled only on the accepting edge. They also assume that a lookup issued during an insert walk sees the slot contents from before that edge. The stimulus drives all inputs on the falling edge. It never overlaps a lookup with a command, so every expected response comes from a model whose state is settled. Before each command the bench waits for `cmd_ready`, which keeps every command outside the walk.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

    localparam int VA_W      = 32;
    localparam int DATA_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int PPN_W     = 20;
    localparam int PPN_LSB   = 5;
    localparam int PROT_LSB  = 1;
    localparam logic [VA_W-1:0] PAGE_LAST = VA_W'((1 << PAGE_BITS) - 1);

    typedef enum logic [1:0] {
        OP_INS_ADDR   = 2'd0,
        OP_INS_PROT   = 2'd1,
        OP_PURGE_PAGE = 2'd2,
        OP_PURGE_ALL  = 2'd3
    } tlb_op_e;

    typedef struct packed {
        logic        t;
        logic        d;
        logic        b;
        logic [2:0]  ar_type;
        logic [1:0]  pl1;
        logic [1:0]  pl2;
        logic        u;
        logic [17:0] access_id;
    } tlb_prot_t;

    localparam int PROT_W = $bits(tlb_prot_t);

    typedef struct packed {
        logic [VA_W-1:0]  beg;
        logic [VA_W-1:0]  fin;
        logic [PPN_W-1:0] ppn;
        tlb_prot_t        prot;
        logic             valid;
    } tlb_entry_t;

    function automatic tlb_entry_t empty_entry();
        tlb_entry_t e;
        e     = '0;
        e.beg = '1;
        return e;
    endfunction

    function automatic logic [VA_W-1:0] page_base(input logic [VA_W-1:0] a);
        return {a[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    endfunction

    function automatic logic [PPN_W-1:0] data_ppn(input logic [DATA_W-1:0] w);
        return w[PPN_LSB +: PPN_W];
    endfunction

    function automatic tlb_prot_t data_prot(input logic [DATA_W-1:0] w);
        return tlb_prot_t'(w[PROT_LSB +: PROT_W]);
    endfunction

endpackage

// File: rtl/swtlb_first_hit.sv
module swtlb_first_hit #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hit_vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/swtlb_array.sv
module swtlb_array
    import swtlb_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   probe_addr,
    input  logic [VA_W-1:0]   lk_addr,
    input  logic [N-1:0]      flush_vec,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [VA_W-1:0]   wa_beg,
    input  logic [PPN_W-1:0]  wa_ppn,
    input  logic              wp_en,
    input  logic [IDX_W-1:0]  wp_idx,
    input  tlb_prot_t         wp_prot,
    input  logic [IDX_W-1:0]  lk_idx,
    output tlb_entry_t        lk_ent,
    output logic [N-1:0]      valid_vec,
    output logic [N-1:0]      probe_hit_vec,
    output logic [N-1:0]      lk_hit_vec
);
    tlb_entry_t ent_all [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        tlb_entry_t slot_q;

        always_ff @(posedge clk) begin
            if (rst || flush_vec[g]) begin
                slot_q <= empty_entry();
            end else if (wa_en && wa_idx == IDX_W'(g)) begin
                slot_q.beg   <= wa_beg;
                slot_q.fin   <= wa_beg + PAGE_LAST;
                slot_q.ppn   <= wa_ppn;
                slot_q.prot  <= '0;
                slot_q.valid <= 1'b0;
            end else if (wp_en && wp_idx == IDX_W'(g)) begin
                slot_q.prot  <= wp_prot;
                slot_q.valid <= 1'b1;
            end
        end

        assign ent_all[g]       = slot_q;
        assign valid_vec[g]     = slot_q.valid;
        assign probe_hit_vec[g] = (slot_q.beg <= probe_addr) && (probe_addr <= slot_q.fin);
        assign lk_hit_vec[g]    = (slot_q.beg <= lk_addr) && (lk_addr <= slot_q.fin);
    end

    assign lk_ent = ent_all[lk_idx];

    AST_ADDR_WRITE_INVALID: assert property (@(posedge clk) disable iff (rst)
        wa_en |=> !valid_vec[$past(wa_idx)]) else $error("addr insert left slot valid"); // R4

    AST_PROT_WRITE_VALID: assert property (@(posedge clk) disable iff (rst)
        (wp_en && !flush_vec[wp_idx]) |=> valid_vec[$past(wp_idx)]) else $error("prot insert did not validate"); // R7

    AST_PURGE_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (&flush_vec) |=> (valid_vec == '0)) else $error("purge-all left a valid slot"); // R10

endmodule

// File: rtl/swtlb_ctrl.sv
module swtlb_ctrl
    import swtlb_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  tlb_op_e           cmd_op,
    input  logic [VA_W-1:0]   cmd_vaddr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_err,
    input  logic              probe_found,
    input  logic [IDX_W-1:0]  probe_idx,
    input  logic [N-1:0]      valid_vec,
    input  logic [N-1:0]      probe_hit_vec,
    output logic [VA_W-1:0]   probe_addr,
    output logic [N-1:0]      flush_vec,
    output logic              wa_en,
    output logic [IDX_W-1:0]  wa_idx,
    output logic [VA_W-1:0]   wa_beg,
    output logic [PPN_W-1:0]  wa_ppn,
    output logic              wp_en,
    output logic [IDX_W-1:0]  wp_idx,
    output tlb_prot_t         wp_prot
);
    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WRITE} ctrl_state_e;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    ctrl_state_e      state_q;
    logic [IDX_W-1:0] scan_q;
    logic [IDX_W-1:0] free_idx_q;
    logic             free_found_q;
    logic [IDX_W-1:0] rr_q;
    logic [VA_W-1:0]  addr_q;
    logic [PPN_W-1:0] ppn_q;
    logic             err_q;

    logic accept;
    logic prot_ok;
    logic scan_free;

    assign cmd_ready  = (state_q == ST_IDLE);
    assign accept     = cmd_valid && cmd_ready;
    assign probe_addr = (state_q == ST_IDLE) ? cmd_vaddr : addr_q;
    assign prot_ok    = probe_found && !valid_vec[probe_idx];
    assign scan_free  = !valid_vec[scan_q] || probe_hit_vec[scan_q];
    assign cmd_err    = err_q;

    always_comb begin
        flush_vec = '0;
        wa_en     = 1'b0;
        wa_idx    = free_found_q ? free_idx_q : rr_q;
        wa_beg    = page_base(addr_q);
        wa_ppn    = ppn_q;
        wp_en     = 1'b0;
        wp_idx    = probe_idx;
        wp_prot   = data_prot(cmd_data);
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd_op)
                        OP_INS_PROT:   wp_en = prot_ok;
                        OP_PURGE_PAGE: if (probe_found && valid_vec[probe_idx]) flush_vec[probe_idx] = 1'b1;
                        OP_PURGE_ALL:  flush_vec = '1;
                        default: ;
                    endcase
                end
            end
            ST_SCAN: begin
                if (valid_vec[scan_q] && probe_hit_vec[scan_q]) flush_vec[scan_q] = 1'b1;
            end
            ST_WRITE: wa_en = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            scan_q       <= '0;
            free_idx_q   <= '0;
            free_found_q <= 1'b0;
            rr_q         <= '0;
            addr_q       <= '0;
            ppn_q        <= '0;
            err_q        <= 1'b0;
        end else begin
            err_q <= accept && (cmd_op == OP_INS_PROT) && !prot_ok;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && cmd_op == OP_INS_ADDR) begin
                        state_q      <= ST_SCAN;
                        scan_q       <= '0;
                        free_found_q <= 1'b0;
                        addr_q       <= cmd_vaddr;
                        ppn_q        <= data_ppn(cmd_data);
                    end
                end
                ST_SCAN: begin
                    if (scan_free) begin
                        free_found_q <= 1'b1;
                        free_idx_q   <= scan_q;
                    end
                    if (scan_q == LAST_IDX) state_q <= ST_WRITE;
                    else                    scan_q  <= scan_q + 1'b1;
                end
                ST_WRITE: begin
                    if (!free_found_q) rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ERR_ONLY_FROM_PROT: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(cmd_valid && cmd_ready && cmd_op == OP_INS_PROT)) else $error("stray error pulse"); // R8

    AST_INSERT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op == OP_INS_ADDR) |=> !cmd_ready) else $error("ready high after insert"); // R4

    AST_RR_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE && !free_found_q) |=>
            (rr_q == (($past(rr_q) == LAST_IDX) ? '0 : $past(rr_q) + 1'b1))) else $error("victim pointer step"); // R6

endmodule

// File: rtl/swtlb.sv
module swtlb
    import swtlb_pkg::*;
#(
    parameter int NUM_ENT = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [31:0]   cmd_vaddr,
    input  logic [31:0]   cmd_data,
    output logic          cmd_err,
    input  logic          lk_req,
    input  logic [31:0]   lk_vaddr,
    output logic          lk_rsp_valid,
    output logic          lk_rsp_miss,
    output logic [19:0]   lk_rsp_ppn,
    output logic [28:0]   lk_rsp_prot
);
    localparam int IDX_W = $clog2(NUM_ENT);

    logic [VA_W-1:0]    probe_addr;
    logic [NUM_ENT-1:0] flush_vec;
    logic               wa_en;
    logic [IDX_W-1:0]   wa_idx;
    logic [VA_W-1:0]    wa_beg;
    logic [PPN_W-1:0]   wa_ppn;
    logic               wp_en;
    logic [IDX_W-1:0]   wp_idx;
    tlb_prot_t          wp_prot;
    logic [NUM_ENT-1:0] valid_vec;
    logic [NUM_ENT-1:0] probe_hit_vec;
    logic [NUM_ENT-1:0] lk_hit_vec;
    logic               probe_found;
    logic [IDX_W-1:0]   probe_idx;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_idx;
    tlb_entry_t         lk_ent;
    logic               lk_hit;

    swtlb_array #(.N(NUM_ENT)) u_array (
        .clk(clk), .rst(rst),
        .probe_addr(probe_addr), .lk_addr(lk_vaddr),
        .flush_vec(flush_vec),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_beg(wa_beg), .wa_ppn(wa_ppn),
        .wp_en(wp_en), .wp_idx(wp_idx), .wp_prot(wp_prot),
        .lk_idx(lk_idx), .lk_ent(lk_ent),
        .valid_vec(valid_vec), .probe_hit_vec(probe_hit_vec), .lk_hit_vec(lk_hit_vec)
    );

    swtlb_first_hit #(.N(NUM_ENT)) u_probe_pick (
        .hit_vec(probe_hit_vec), .found(probe_found), .idx(probe_idx)
    );

    swtlb_first_hit #(.N(NUM_ENT)) u_lookup_pick (
        .hit_vec(lk_hit_vec), .found(lk_found), .idx(lk_idx)
    );

    swtlb_ctrl #(.N(NUM_ENT)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(tlb_op_e'(cmd_op)), .cmd_vaddr(cmd_vaddr), .cmd_data(cmd_data),
        .cmd_err(cmd_err),
        .probe_found(probe_found), .probe_idx(probe_idx),
        .valid_vec(valid_vec), .probe_hit_vec(probe_hit_vec),
        .probe_addr(probe_addr), .flush_vec(flush_vec),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_beg(wa_beg), .wa_ppn(wa_ppn),
        .wp_en(wp_en), .wp_idx(wp_idx), .wp_prot(wp_prot)
    );

    assign lk_hit = lk_found && lk_ent.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_rsp_valid <= 1'b0;
            lk_rsp_miss  <= 1'b0;
            lk_rsp_ppn   <= '0;
            lk_rsp_prot  <= '0;
        end else begin
            lk_rsp_valid <= lk_req;
            if (lk_req) begin
                lk_rsp_miss <= !lk_hit;
                lk_rsp_ppn  <= lk_hit ? lk_ent.ppn : '0;
                lk_rsp_prot <= lk_hit ? lk_ent.prot : '0;
            end
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_rsp_valid) else $error("lookup response missing"); // R2

    AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (lk_rsp_valid && lk_rsp_miss) |-> (lk_rsp_ppn == '0 && lk_rsp_prot == '0)) else $error("miss carries data"); // R3

endmodule

// File: tb/tb_swtlb.sv
module tb_swtlb;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_vaddr = '0;
    logic [31:0] cmd_data = '0;
    logic        cmd_err;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_rsp_valid;
    logic        lk_rsp_miss;
    logic [19:0] lk_rsp_ppn;
    logic [28:0] lk_rsp_prot;

    always #5 clk = ~clk;

    swtlb #(.NUM_ENT(NE)) dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_vaddr(cmd_vaddr), .cmd_data(cmd_data), .cmd_err(cmd_err),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_miss(lk_rsp_miss),
        .lk_rsp_ppn(lk_rsp_ppn), .lk_rsp_prot(lk_rsp_prot)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model
    logic [31:0] m_beg  [NE];
    logic [31:0] m_end  [NE];
    logic [19:0] m_ppn  [NE];
    logic [28:0] m_prot [NE];
    bit          m_val  [NE];
    int          m_rr;

    // scoreboard queues
    bit          q_miss [$];
    logic [19:0] q_ppn  [$];
    logic [28:0] q_prot [$];
    string       q_tag  [$];

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic m_empty(input int i);
        m_beg[i] = '1; m_end[i] = '0; m_ppn[i] = '0; m_prot[i] = '0; m_val[i] = 1'b0;
    endtask

    function automatic int m_find(input logic [31:0] a);
        for (int i = 0; i < NE; i++)
            if (m_beg[i] <= a && a <= m_end[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] addr_word(input logic [19:0] ppn);
        return {7'b1010101, ppn, 5'b11011};
    endfunction

    function automatic logic [31:0] prot_word(input logic [28:0] p);
        return {2'b11, p, 1'b1};
    endfunction

    // monitor
    always @(negedge clk) begin
        if (lk_rsp_valid) begin
            if (q_miss.size() == 0) begin
                check("R2", "response without request", 64'd1, 64'd0);
            end else begin
                bit          em;
                logic [19:0] ep;
                logic [28:0] epr;
                string       tg;
                em  = q_miss.pop_front();
                ep  = q_ppn.pop_front();
                epr = q_prot.pop_front();
                tg  = q_tag.pop_front();
                check(tg, "miss", {63'd0, lk_rsp_miss}, {63'd0, em});
                check(tg, "ppn",  {44'd0, lk_rsp_ppn}, {44'd0, ep});
                check(tg, "prot", {35'd0, lk_rsp_prot}, {35'd0, epr});
            end
        end
    end

    task automatic lookup(input logic [31:0] a, input string tag);
        int i;
        bit hit;
        @(negedge clk);
        lk_req   = 1'b1;
        lk_vaddr = a;
        i   = m_find(a);
        hit = (i >= 0) && m_val[i];
        q_miss.push_back(!hit);
        q_ppn.push_back(hit ? m_ppn[i] : 20'd0);
        q_prot.push_back(hit ? m_prot[i] : 29'd0);
        q_tag.push_back(tag);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic command(input logic [1:0] op, input logic [31:0] a,
                           input logic [31:0] d, input string tag);
        int  i;
        int  fr;
        int  busy;
        bit  exp_err;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_vaddr = a; cmd_data = d;
        exp_err = 1'b0;
        case (op)
            2'd0: begin
                fr = -1;
                for (int k = 0; k < NE; k++) begin
                    if (!m_val[k]) fr = k;
                    else if (m_beg[k] <= a && a <= m_end[k]) begin m_empty(k); fr = k; end
                end
                if (fr < 0) begin fr = m_rr; m_rr = (m_rr == NE - 1) ? 0 : m_rr + 1; end
                m_beg[fr]  = {a[31:12], 12'h000};
                m_end[fr]  = {a[31:12], 12'hFFF};
                m_ppn[fr]  = d[24:5];
                m_prot[fr] = '0;
                m_val[fr]  = 1'b0;
            end
            2'd1: begin
                i = m_find(a);
                if (i < 0 || m_val[i]) exp_err = 1'b1;
                else begin m_prot[i] = d[29:1]; m_val[i] = 1'b1; end
            end
            2'd2: begin
                i = m_find(a);
                if (i >= 0 && m_val[i]) m_empty(i);
            end
            default: for (int k = 0; k < NE; k++) m_empty(k);
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        check(op == 2'd1 ? "R8" : tag, "cmd_err", {63'd0, cmd_err}, {63'd0, exp_err});
        if (op == 2'd0) begin
            busy = 0;
            while (!cmd_ready && busy < 100) begin busy++; @(negedge clk); end
            check("R4", "busy cycles", 64'(busy), 64'(NE + 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [28:0] p0;
        for (int k = 0; k < NE; k++) m_empty(k);
        m_rr = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "cmd_ready", {63'd0, cmd_ready}, 64'd1);
        check("R1", "cmd_err", {63'd0, cmd_err}, 64'd0);
        check("R1", "rsp_valid", {63'd0, lk_rsp_valid}, 64'd0);
        lookup(32'h0000_1000, "R1");
        lookup(32'hFFFF_FFFF, "R1");

        // R4 address insert, R3 invalid match misses
        command(2'd0, 32'h0001_2345, addr_word(20'hABCDE), "R4");
        lookup(32'h0001_2000, "R3");
        // R7 protection fields
        p0 = {1'b1, 1'b0, 1'b1, 3'd5, 2'd2, 2'd1, 1'b1, 18'h2A5A5};
        command(2'd1, 32'h0001_2800, prot_word(p0), "R7");
        lookup(32'h0001_2000, "R2");
        lookup(32'h0001_2FFF, "R4");
        lookup(32'h0001_3000, "R4");
        lookup(32'h0001_1FFF, "R4");

        // R8 rejected protection inserts
        command(2'd1, 32'h0001_2000, prot_word(29'h0F0F0F0F), "R8");
        lookup(32'h0001_2400, "R8");
        command(2'd1, 32'h0009_9000, prot_word(29'h1234567), "R8");
        lookup(32'h0009_9000, "R8");

        // R5 overlapping valid entry is emptied by a new insert
        command(2'd0, 32'h0001_2ABC, addr_word(20'h13579), "R5");
        lookup(32'h0001_2000, "R5");
        command(2'd1, 32'h0001_2000, prot_word(29'h1ACE0FF), "R7");
        lookup(32'h0001_2FF0, "R5");

        // R9 page purge only empties a valid match
        command(2'd0, 32'h0004_0000, addr_word(20'h00440), "R9");
        command(2'd2, 32'h0004_0000, 32'h0, "R9");
        command(2'd1, 32'h0004_0010, prot_word(29'h0000_0AB), "R9");
        lookup(32'h0004_0010, "R9");
        command(2'd2, 32'h0004_0123, 32'h0, "R9");
        lookup(32'h0004_0010, "R9");
        command(2'd1, 32'h0004_0000, prot_word(29'h1), "R9");
        lookup(32'h0001_2000, "R9");

        // R10 purge all
        command(2'd3, 32'h0, 32'h0, "R10");
        lookup(32'h0001_2000, "R10");
        lookup(32'h0004_0000, "R10");

        // R5 fill from the top, R6 victim rotation
        for (int k = 0; k < NE; k++) begin
            command(2'd0, 32'h0010_0000 + 32'(k) * 32'h1000, addr_word(20'(k + 1)), "R5");
            command(2'd1, 32'h0010_0000 + 32'(k) * 32'h1000, prot_word(29'(k * 32'h0123_4567)), "R7");
        end
        command(2'd0, 32'h0020_0000, addr_word(20'hFEED0), "R6");
        command(2'd1, 32'h0020_0000, prot_word(29'h0BEEF), "R6");
        for (int k = 0; k < NE; k++) lookup(32'h0010_0000 + 32'(k) * 32'h1000, "R5");
        lookup(32'h0020_0000, "R6");
        for (int k = 0; k < NE + 1; k++) begin
            command(2'd0, 32'h0030_0000 + 32'(k) * 32'h1000, addr_word(20'(k + 32'h100)), "R6");
            command(2'd1, 32'h0030_0000 + 32'(k) * 32'h1000, prot_word(29'(k + 7)), "R6");
            lookup(32'h0030_0000 + 32'(k) * 32'h1000, "R6");
        end
        for (int k = 0; k < NE + 1; k++) lookup(32'h0030_0000 + 32'(k) * 32'h1000, "R6");
        for (int k = 0; k < NE; k++) lookup(32'h0010_0000 + 32'(k) * 32'h1000, "R6");
        lookup(32'h0020_0000, "R6");

        repeat (4) @(negedge clk);
        check("R2", "pending responses", 64'(q_miss.size()), 64'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule